// File: doc/BRIEF.md
# Bitwise-Invert Instruction Decode and Execute Unit

This unit takes an instruction byte stream, one byte per clock cycle, qualified by a valid strobe. It recognises the one's-complement inversion instruction. That instruction may carry lock, operand-size and REX prefixes in any mix, followed by the opcode byte and then the ModRM byte. The unit always runs in 64-bit mode. From the prefixes and the opcode it works out the operand width.

When the ModRM byte names a register destination, the unit reads that entry of its internal sixteen-entry, 64-bit register file. It inverts every bit that lies inside the operand width and writes the merged value back in the same clock cycle. A memory destination produces no address. The unit only raises a one-cycle memory request that carries the width and the lock flag. An illegal encoding raises a one-cycle undefined-opcode fault, and the decoder then waits for a new instruction.

Neighbouring logic can load whole register entries through a write port and can inspect any entry through a combinational read port. A flags register sits beside the datapath. Only its own load port ever changes it.

Top module: `notx_top`

## Requirements
- R1: Opcode 0xF6 works on 8 bits and opcode 0xF7 works on a wider operand. Both need ModRM bits 5:3 (the extension field) to equal 2.
- R2: For opcode 0xF7 the width is chosen in this order. A REX byte (0x40 to 0x4F) with bit 3 set gives 64 bits. Otherwise a 0x66 prefix gives 16 bits. Otherwise the width is 32 bits.
- R3: When ModRM bits 7:6 equal 3, the register named by the ModRM bits 2:0 is read. Every bit inside the width is inverted, and the result is written back at the clock edge that takes the ModRM byte. reg_done_o then pulses for one cycle. A 32-bit write clears bits 63:32. An 8-bit or 16-bit write keeps all bits outside the operand.
- R4: For an 8-bit operand with no REX byte, r/m codes 0 to 3 select bits 7:0 of entries 0 to 3, and r/m codes 4 to 7 select bits 15:8 of entries 0 to 3. With a REX byte, r/m codes 4 to 7 select bits 7:0 of entries 4 to 7.
- R5: REX bit 0 becomes bit 3 of the register index at every width, which reaches entries 8 to 15.
- R6: A REX byte takes effect only when it is the last prefix before the opcode. A 0xF0 or 0x66 byte that follows it cancels it.
- R7: A lock prefix (0xF0) together with a register destination raises ud_fault_o for one cycle and writes no register.
- R8: An opcode byte that is neither a prefix nor 0xF6/0xF7 raises ud_fault_o on the next cycle, and so does a ModRM byte whose extension field is not 2. Neither writes a register, and the decoder then accepts a fresh instruction.
- R9: A memory destination (ModRM bits 7:6 not equal to 3) pulses mem_req_o for one cycle and writes no register. While mem_req_o is high, mem_sz_o gives the width (0 = 8, 1 = 16, 2 = 32, 3 = 64 bits) and mem_lock_o gives the lock prefix.
- R10: flags_o is never changed by an instruction. It loads flags_i only at an edge where flags_we_i is high.
- R11: After reset, every register entry, flags_o and all pulse outputs are zero.
- R12: ext_we_i loads a whole entry at the clock edge. If an instruction writes the same entry at the same edge, the instruction's result is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| byte_vld_i | input | 1 | Instruction byte valid |
| byte_i | input | 8 | Instruction byte |
| ext_we_i | input | 1 | External register write enable |
| ext_idx_i | input | 4 | External write entry index |
| ext_data_i | input | 64 | External write data |
| peek_idx_i | input | 4 | Read port entry index |
| peek_data_o | output | 64 | Read port data (combinational) |
| flags_we_i | input | 1 | Flags load enable |
| flags_i | input | FLAG_W | Flags load value |
| flags_o | output | FLAG_W | Flags register |
| reg_done_o | output | 1 | Register result written (pulse) |
| ud_fault_o | output | 1 | Undefined-opcode fault (pulse) |
| mem_req_o | output | 1 | Memory destination request (pulse) |
| mem_sz_o | output | 2 | Width code of the memory request |
| mem_lock_o | output | 1 | Lock flag of the memory request |

## Verification
The bench builds the unit with its default sixteen entries and an 8-bit flags register. Every REX.B target from 8 to 15 and every high-byte alias of entries 0 to 3 is therefore reachable, and the bench compares all of them after each instruction. Random prefix chains of up to three bytes exercise REX cancellation and the interaction of lock, width and destination kind. Write collisions on the same edge between the external port and the instruction are also driven and checked.

// File: rtl/notx_pkg.sv
package notx_pkg;
  localparam int unsigned DATA_W  = 64;
  localparam int unsigned RIDX_W  = 4;
  localparam int unsigned REG_CNT = 2 ** RIDX_W;

  localparam logic [7:0] PFX_LOCK   = 8'hF0;
  localparam logic [7:0] PFX_OPSZ   = 8'h66;
  localparam logic [3:0] PFX_REX_HI = 4'h4;
  localparam logic [7:0] OPC_NARROW = 8'hF6;
  localparam logic [7:0] OPC_WIDE   = 8'hF7;
  localparam logic [2:0] EXT_INVERT = 3'd2;
  localparam logic [1:0] MOD_REG    = 2'b11;

  typedef enum logic [1:0] {SZ8 = 2'd0, SZ16 = 2'd1, SZ32 = 2'd2, SZ64 = 2'd3} opsz_e;
  typedef enum logic {ST_PFX = 1'b0, ST_MODRM = 1'b1} dstate_e;

  typedef struct packed {
    logic lock;
    logic opsz;
    logic rex_vld;
    logic rex_w;
    logic rex_b;
  } pfx_t;

  localparam pfx_t PFX_NONE = '0;

  typedef struct packed {
    logic [RIDX_W-1:0] idx;
    logic              hi_byte;
    opsz_e             sz;
  } dst_t;
endpackage

// File: rtl/notx_decode.sv
module notx_decode
  import notx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       byte_vld_i,
  input  logic [7:0] byte_i,
  output logic       ud_go_o,
  output logic       reg_go_o,
  output logic       mem_go_o,
  output logic       lock_o,
  output dst_t       dst_o
);
  dstate_e st_q, st_d;
  pfx_t    pfx_q, pfx_d;
  logic    wide_q, wide_d;

  logic [1:0] f_mod;
  logic [2:0] f_ext;
  logic [2:0] f_rm;

  assign f_mod = byte_i[7:6];
  assign f_ext = byte_i[5:3];
  assign f_rm  = byte_i[2:0];

  // next-state
  always_comb begin
    st_d     = st_q;
    pfx_d    = pfx_q;
    wide_d   = wide_q;
    ud_go_o  = 1'b0;
    reg_go_o = 1'b0;
    mem_go_o = 1'b0;
    if (byte_vld_i) begin
      unique case (st_q)
        ST_PFX: begin
          if (byte_i == PFX_LOCK) begin
            pfx_d.lock    = 1'b1;
            pfx_d.rex_vld = 1'b0;
            pfx_d.rex_w   = 1'b0;
            pfx_d.rex_b   = 1'b0;
          end else if (byte_i == PFX_OPSZ) begin
            pfx_d.opsz    = 1'b1;
            pfx_d.rex_vld = 1'b0;
            pfx_d.rex_w   = 1'b0;
            pfx_d.rex_b   = 1'b0;
          end else if (byte_i[7:4] == PFX_REX_HI) begin
            pfx_d.rex_vld = 1'b1;
            pfx_d.rex_w   = byte_i[3];
            pfx_d.rex_b   = byte_i[0];
          end else if (byte_i == OPC_NARROW || byte_i == OPC_WIDE) begin
            wide_d = byte_i[0];
            st_d   = ST_MODRM;
          end else begin
            ud_go_o = 1'b1;
            pfx_d   = PFX_NONE;
          end
        end
        ST_MODRM: begin
          st_d   = ST_PFX;
          pfx_d  = PFX_NONE;
          wide_d = 1'b0;
          if (f_ext != EXT_INVERT) begin
            ud_go_o = 1'b1;
          end else if (f_mod != MOD_REG) begin
            mem_go_o = 1'b1;
          end else if (pfx_q.lock) begin
            ud_go_o = 1'b1;
          end else begin
            reg_go_o = 1'b1;
          end
        end
        default: st_d = ST_PFX;
      endcase
    end
  end

  // width and destination selection
  always_comb begin
    dst_o.hi_byte = 1'b0;
    dst_o.idx     = {pfx_q.rex_b, f_rm};
    if (!wide_q) begin
      dst_o.sz = SZ8;
      if (!pfx_q.rex_vld && f_rm[2]) begin
        dst_o.hi_byte = 1'b1;
        dst_o.idx     = {2'b00, f_rm[1:0]};
      end
    end else if (pfx_q.rex_w) begin
      dst_o.sz = SZ64;
    end else if (pfx_q.opsz) begin
      dst_o.sz = SZ16;
    end else begin
      dst_o.sz = SZ32;
    end
  end

  assign lock_o = pfx_q.lock;

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_PFX;
      pfx_q  <= PFX_NONE;
      wide_q <= 1'b0;
    end else if (byte_vld_i) begin
      st_q   <= st_d;
      pfx_q  <= pfx_d;
      wide_q <= wide_d;
    end
  end

  // R1
  opcode_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld_i && st_q == ST_PFX && (byte_i == OPC_NARROW || byte_i == OPC_WIDE))
      |=> (st_q == ST_MODRM))
    else $error("opcode_arm_chk");

  // R6
  rex_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld_i && st_q == ST_PFX && (byte_i == PFX_LOCK || byte_i == PFX_OPSZ))
      |=> !pfx_q.rex_vld)
    else $error("rex_last_chk");

  // R7
  lock_reg_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld_i && st_q == ST_MODRM && pfx_q.lock && f_mod == MOD_REG)
      |-> (ud_go_o && !reg_go_o))
    else $error("lock_reg_fault_chk");

  // R8
  fault_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ud_go_o |=> (st_q == ST_PFX && pfx_q == PFX_NONE))
    else $error("fault_rearm_chk");
endmodule

// File: rtl/notx_exec.sv
module notx_exec
  import notx_pkg::*;
(
  input  logic [DATA_W-1:0] rd_i,
  input  dst_t              dst_i,
  output logic [DATA_W-1:0] wd_o
);
  localparam int unsigned LANES = DATA_W / 8;

  logic [LANES-1:0] flip;
  logic             clr_up;

  always_comb begin
    flip   = '0;
    clr_up = 1'b0;
    unique case (dst_i.sz)
      SZ8:     flip[dst_i.hi_byte ? 1 : 0] = 1'b1;
      SZ16:    flip[1:0] = 2'b11;
      SZ32:    begin flip[LANES/2-1:0] = '1; clr_up = 1'b1; end
      default: flip = '1;
    endcase
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_comb begin
      if (flip[g])                      wd_o[g*8 +: 8] = ~rd_i[g*8 +: 8];
      else if (clr_up && g >= LANES/2)  wd_o[g*8 +: 8] = 8'h00;
      else                              wd_o[g*8 +: 8] = rd_i[g*8 +: 8];
    end
  end
endmodule

// File: rtl/notx_regfile.sv
module notx_regfile #(
  parameter int unsigned REG_CNT = 16,
  parameter int unsigned DATA_W  = 64
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     x_we_i,
  input  logic [$clog2(REG_CNT)-1:0] x_idx_i,
  input  logic [DATA_W-1:0]        x_wd_i,
  input  logic                     e_we_i,
  input  logic [$clog2(REG_CNT)-1:0] e_idx_i,
  input  logic [DATA_W-1:0]        e_wd_i,
  input  logic [$clog2(REG_CNT)-1:0] ra_idx_i,
  output logic [DATA_W-1:0]        ra_o,
  input  logic [$clog2(REG_CNT)-1:0] rb_idx_i,
  output logic [DATA_W-1:0]        rb_o
);
  localparam int unsigned IDX_W = $clog2(REG_CNT);

  logic [REG_CNT-1:0][DATA_W-1:0] ent_all;

  for (genvar g = 0; g < REG_CNT; g++) begin : g_ent
    logic              hit_x, hit_e;
    logic [DATA_W-1:0] ent_d, ent_q;

    always_comb begin
      hit_x = x_we_i && (x_idx_i == IDX_W'(g));
      hit_e = e_we_i && (e_idx_i == IDX_W'(g));
      ent_d = hit_x ? x_wd_i : e_wd_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              ent_q <= '0;
      else if (hit_x || hit_e) ent_q <= ent_d;
    end

    assign ent_all[g] = ent_q;
  end

  assign ra_o = ent_all[ra_idx_i];
  assign rb_o = ent_all[rb_idx_i];

  // R12
  exec_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (x_we_i && e_we_i && x_idx_i == e_idx_i)
      |=> (ent_all[$past(x_idx_i)] == $past(x_wd_i)))
    else $error("exec_wins_chk");
endmodule

// File: rtl/notx_top.sv
module notx_top
  import notx_pkg::*;
#(
  parameter int unsigned FLAG_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_vld_i,
  input  logic [7:0]        byte_i,
  input  logic              ext_we_i,
  input  logic [RIDX_W-1:0] ext_idx_i,
  input  logic [DATA_W-1:0] ext_data_i,
  input  logic [RIDX_W-1:0] peek_idx_i,
  output logic [DATA_W-1:0] peek_data_o,
  input  logic              flags_we_i,
  input  logic [FLAG_W-1:0] flags_i,
  output logic [FLAG_W-1:0] flags_o,
  output logic              reg_done_o,
  output logic              ud_fault_o,
  output logic              mem_req_o,
  output logic [1:0]        mem_sz_o,
  output logic              mem_lock_o
);
  // reset: asserted asynchronously, released on the clock
  logic [1:0] rsync_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_i_n = rsync_q[1];

  logic              ud_go, reg_go, mem_go, lock_q;
  dst_t              dst;
  logic [DATA_W-1:0] rd_val, wd_val;

  notx_decode u_dec (
    .clk        (clk),
    .rst_n      (rst_i_n),
    .byte_vld_i (byte_vld_i),
    .byte_i     (byte_i),
    .ud_go_o    (ud_go),
    .reg_go_o   (reg_go),
    .mem_go_o   (mem_go),
    .lock_o     (lock_q),
    .dst_o      (dst)
  );

  notx_exec u_exec (
    .rd_i  (rd_val),
    .dst_i (dst),
    .wd_o  (wd_val)
  );

  notx_regfile #(.REG_CNT(REG_CNT), .DATA_W(DATA_W)) u_rf (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .x_we_i   (reg_go),
    .x_idx_i  (dst.idx),
    .x_wd_i   (wd_val),
    .e_we_i   (ext_we_i),
    .e_idx_i  (ext_idx_i),
    .e_wd_i   (ext_data_i),
    .ra_idx_i (dst.idx),
    .ra_o     (rd_val),
    .rb_idx_i (peek_idx_i),
    .rb_o     (peek_data_o)
  );

  // status and flags next-state
  logic [FLAG_W-1:0] flags_d, flags_q;
  logic [1:0]        msz_d, msz_q;
  logic              mlk_d, mlk_q;
  logic              done_q, ud_q, mreq_q;

  always_comb begin
    flags_d = flags_q;
    msz_d   = msz_q;
    mlk_d   = mlk_q;
    if (flags_we_i) flags_d = flags_i;
    if (mem_go) begin
      msz_d = dst.sz;
      mlk_d = lock_q;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      flags_q <= '0;
      msz_q   <= 2'b00;
      mlk_q   <= 1'b0;
      done_q  <= 1'b0;
      ud_q    <= 1'b0;
      mreq_q  <= 1'b0;
    end else begin
      flags_q <= flags_d;
      msz_q   <= msz_d;
      mlk_q   <= mlk_d;
      done_q  <= reg_go;
      ud_q    <= ud_go;
      mreq_q  <= mem_go;
    end
  end

  assign flags_o    = flags_q;
  assign mem_sz_o   = msz_q;
  assign mem_lock_o = mlk_q;
  assign reg_done_o = done_q;
  assign ud_fault_o = ud_q;
  assign mem_req_o  = mreq_q;

  // R3 R8 R9
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    $onehot0({reg_done_o, ud_fault_o, mem_req_o}))
    else $error("one_outcome_chk");

  // R10
  flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    !flags_we_i |=> $stable(flags_o))
    else $error("flags_hold_chk");

  // R3
  zext_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (reg_go && dst.sz == SZ32) |-> (wd_val[DATA_W-1:32] == '0))
    else $error("zext_chk");

  // R3
  byte_keep_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (reg_go && dst.sz == SZ8 && !dst.hi_byte) |-> (wd_val[DATA_W-1:8] == rd_val[DATA_W-1:8]))
    else $error("byte_keep_chk");
endmodule

// File: tb/notx_top_test.sv
module notx_top_test;
  localparam int CLK_NS = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        byte_vld_i;
  logic [7:0]  byte_i;
  logic        ext_we_i;
  logic [3:0]  ext_idx_i;
  logic [63:0] ext_data_i;
  logic [3:0]  peek_idx_i;
  logic [63:0] peek_data_o;
  logic        flags_we_i;
  logic [7:0]  flags_i;
  logic [7:0]  flags_o;
  logic        reg_done_o, ud_fault_o, mem_req_o, mem_lock_o;
  logic [1:0]  mem_sz_o;

  notx_top #(.FLAG_W(8)) uut (.*);

  always #(CLK_NS/2) clk = ~clk;

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;
  logic [63:0] mdl [16];
  logic [7:0]  fl_mdl;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_err = n_err + 1;
      $display("FAIL watchdog act=%0d exp=<150000", cyc);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic peek_all(input string req);
    for (int i = 0; i < 16; i++) begin
      peek_idx_i = 4'(i);
      #1;
      chk(req, peek_data_o, mdl[i]);
    end
  endtask

  task automatic put_byte(input logic [7:0] b);
    @(negedge clk);
    byte_vld_i = 1'b1;
    byte_i     = b;
  endtask

  task automatic ext_load(input logic [3:0] idx, input logic [63:0] v);
    @(negedge clk);
    byte_vld_i = 1'b0;
    ext_we_i = 1'b1; ext_idx_i = idx; ext_data_i = v;
    @(negedge clk);
    ext_we_i = 1'b0;
    mdl[idx] = v;
  endtask

  task automatic flag_load(input logic [7:0] v);
    @(negedge clk);
    byte_vld_i = 1'b0;
    flags_we_i = 1'b1; flags_i = v;
    @(negedge clk);
    flags_we_i = 1'b0;
    fl_mdl = v;
  endtask

  function automatic logic [63:0] inv_model(input logic [63:0] v, input logic [1:0] sz, input logic hi);
    logic [63:0] r;
    r = v;
    case (sz)
      2'd0: if (hi) r[15:8] = ~v[15:8]; else r[7:0] = ~v[7:0];
      2'd1: r[15:0] = ~v[15:0];
      2'd2: r = {32'h0, ~v[31:0]};
      default: r = ~v;
    endcase
    return r;
  endfunction

  task automatic do_ins(input logic [2:0][7:0] pf, input int np, input logic [7:0] opc,
                        input logic [7:0] modrm, input logic cen, input logic [3:0] cidx,
                        input logic [63:0] cdat, input string tag);
    logic lk, os, rx, rw, rb, hi, e_ud, e_mem, e_wr;
    logic [1:0] sz, md;
    logic [2:0] rg, rm;
    logic [3:0] idx;
    lk = 0; os = 0; rx = 0; rw = 0; rb = 0;
    for (int i = 0; i < np; i++) begin
      if (pf[i] == 8'hF0)      begin lk = 1; rx = 0; rw = 0; rb = 0; end
      else if (pf[i] == 8'h66) begin os = 1; rx = 0; rw = 0; rb = 0; end
      else                     begin rx = 1; rw = pf[i][3]; rb = pf[i][0]; end
      put_byte(pf[i]);
    end
    put_byte(opc);
    if (opc != 8'hF6 && opc != 8'hF7) begin
      @(negedge clk);
      byte_vld_i = 1'b0;
      chk({tag, " R8 bad opcode fault"}, 64'(ud_fault_o), 64'd1);
      chk({tag, " R8 bad opcode no done"}, 64'(reg_done_o), 64'd0);
      peek_all({tag, " R8 regs untouched"});
      return;
    end
    md = modrm[7:6]; rg = modrm[5:3]; rm = modrm[2:0];
    if (opc == 8'hF6) sz = 2'd0;
    else if (rw)      sz = 2'd3;
    else if (os)      sz = 2'd1;
    else              sz = 2'd2;
    hi = 1'b0; idx = {rb, rm};
    if (sz == 2'd0 && !rx && rm[2]) begin hi = 1'b1; idx = {2'b00, rm[1:0]}; end
    e_ud  = (rg != 3'd2) || (md == 2'd3 && lk);
    e_mem = !e_ud && md != 2'd3;
    e_wr  = !e_ud && !e_mem;
    @(negedge clk);
    byte_vld_i = 1'b1; byte_i = modrm;
    ext_we_i = cen; ext_idx_i = cidx; ext_data_i = cdat;
    @(negedge clk);
    byte_vld_i = 1'b0; ext_we_i = 1'b0;
    if (e_wr) mdl[idx] = inv_model(mdl[idx], sz, hi);
    if (cen && !(e_wr && idx == cidx)) mdl[cidx] = cdat;
    chk({tag, (rg != 3'd2) ? " R8 ext field fault" : " R7 lock fault"}, 64'(ud_fault_o), 64'(e_ud));
    chk({tag, " R9 mem request"}, 64'(mem_req_o), 64'(e_mem));
    chk({tag, " R3 write done"}, 64'(reg_done_o), 64'(e_wr));
    if (e_mem) begin
      chk({tag, " R9 mem width"}, 64'(mem_sz_o), 64'(sz));
      chk({tag, " R9 mem lock"}, 64'(mem_lock_o), 64'(lk));
    end
    peek_all({tag, " R3 register file"});
    chk({tag, " R10 flags held"}, 64'(flags_o), 64'(fl_mdl));
  endtask

  initial begin
    logic [2:0][7:0] pf;
    logic [7:0] opc, mr;
    int np;
    void'($urandom(32'h5eed_0042));
    rst_n = 1'b0; byte_vld_i = 0; byte_i = 0; ext_we_i = 0; ext_idx_i = 0;
    ext_data_i = 0; peek_idx_i = 0; flags_we_i = 0; flags_i = 0; fl_mdl = 0;
    for (int i = 0; i < 16; i++) mdl[i] = 64'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R11 reset state
    chk("R11 done idle", 64'(reg_done_o), 64'd0);
    chk("R11 fault idle", 64'(ud_fault_o), 64'd0);
    chk("R11 mem idle", 64'(mem_req_o), 64'd0);
    chk("R11 flags zero", 64'(flags_o), 64'd0);
    peek_all("R11 regs zero");

    for (int i = 0; i < 16; i++)
      ext_load(4'(i), 64'h1111_2222_3333_4444 * 64'(i + 1) ^ 64'hA5C3_0F96_5A3C_F069);
    peek_all("R12 external load");

    // R4 high byte without REX
    do_ins('0, 0, 8'hF6, 8'hD4, 0, 0, 0, "R4 hi byte r0");
    do_ins('0, 0, 8'hF6, 8'hD7, 0, 0, 0, "R4 hi byte r3");
    // R4 low byte of entry 4 with REX
    do_ins({16'h0, 8'h40}, 1, 8'hF6, 8'hD4, 0, 0, 0, "R4 rex low byte r4");
    // R5 / R2 / R3
    do_ins({16'h0, 8'h41}, 1, 8'hF7, 8'hD7, 0, 0, 0, "R5 R3 r15 32-bit zext");
    do_ins({16'h0, 8'h48}, 1, 8'hF7, 8'hD0, 0, 0, 0, "R2 64-bit r0");
    do_ins({16'h0, 8'h66}, 1, 8'hF7, 8'hD1, 0, 0, 0, "R2 16-bit r1");
    do_ins({16'h0, 8'h49}, 1, 8'hF6, 8'hD2, 0, 0, 0, "R5 byte r10");
    // R6 REX cancelled by a later prefix
    do_ins({8'h0, 8'h66, 8'h48}, 2, 8'hF7, 8'hD2, 0, 0, 0, "R6 rex then opsz");
    do_ins({8'h0, 8'h66, 8'h40}, 2, 8'hF6, 8'hD5, 0, 0, 0, "R6 rex cancelled hi byte");
    do_ins({8'h0, 8'h48, 8'h66}, 2, 8'hF7, 8'hD3, 0, 0, 0, "R2 rexw over opsz");
    // R7 lock with register destination
    do_ins({16'h0, 8'hF0}, 1, 8'hF7, 8'hD3, 0, 0, 0, "R7 lock reg");
    // R9 memory destinations
    do_ins({16'h0, 8'hF0}, 1, 8'hF7, 8'h13, 0, 0, 0, "R9 lock mem 32");
    do_ins({16'h0, 8'h66}, 1, 8'hF7, 8'h55, 0, 0, 0, "R9 mem 16");
    do_ins({8'h0, 8'hF0, 8'h48}, 2, 8'hF6, 8'h96, 0, 0, 0, "R9 mem 8");
    // R8 illegal encodings, then recovery
    do_ins('0, 0, 8'hF7, 8'hC3, 0, 0, 0, "R8 ext field 0");
    do_ins({16'h0, 8'hF0}, 1, 8'h90, 8'h00, 0, 0, 0, "R8 bad opcode");
    do_ins('0, 0, 8'hF6, 8'hD0, 0, 0, 0, "R8 recovery R1 byte r0");
    // R10 flags untouched by execution
    flag_load(8'h5A);
    do_ins({16'h0, 8'h48}, 1, 8'hF7, 8'hD6, 0, 0, 0, "R10 flags after exec");
    // R12 collision: instruction result kept
    do_ins('0, 0, 8'hF6, 8'hD0, 1, 4'd0, 64'hDEAD_BEEF_0000_0000, "R12 collision same");
    do_ins('0, 0, 8'hF6, 8'hD0, 1, 4'd9, 64'h0123_4567_89AB_CDEF, "R12 collision other");

    // random mix
    for (int t = 0; t < 400; t++) begin
      np = int'($urandom % 4);
      for (int i = 0; i < 3; i++) begin
        case ($urandom % 8)
          0:       pf[i] = 8'hF0;
          1, 2:    pf[i] = 8'h66;
          default: pf[i] = 8'h40 | 8'($urandom % 16);
        endcase
      end
      if ($urandom % 16 == 0) begin
        case ($urandom % 4)
          0: opc = 8'h90; 1: opc = 8'h00; 2: opc = 8'hFE; default: opc = 8'hF5;
        endcase
      end else begin
        opc = ($urandom % 2 == 0) ? 8'hF6 : 8'hF7;
      end
      mr[7:6] = ($urandom % 4 == 0) ? 2'($urandom % 3) : 2'b11;
      mr[5:3] = ($urandom % 8 == 0) ? 3'($urandom % 2) : 3'd2;
      mr[2:0] = 3'($urandom);
      do_ins(pf, np, opc, mr, ($urandom % 8 == 0), 4'($urandom), {$urandom, $urandom}, "R3 random");
      if (t % 10 == 0) ext_load(4'($urandom), {$urandom, $urandom});
      if (t % 37 == 0) flag_load(8'($urandom));
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule